// File: doc/BRIEF.md
# Almost-Empty / Almost-Full Threshold Programming Port

This block sits beside a FIFO's storage and holds the two threshold values that the flag logic compares against the fill level. The almost-empty threshold is the number of unread words at or below which the almost-empty flag is raised. The almost-full threshold is the distance from full at which the almost-full flag is raised. Each threshold is kept as two data-width registers, a low part and a high part. That makes four registers behind the FIFO's ordinary write and read ports.

An active-low configuration select steers the FIFO's write and read strobes. With the select low, a write enable stores the input word into one threshold register, and a read enable copies one register into the read-data register. With the select high, the strobes pass through as ordinary memory write and read requests. No address is presented. A single internal pointer chooses the register, advances after every register access in either direction, and wraps around a fixed four-step cycle. The pointer keeps its position while the select is high.

The block runs with the write and read sides on one clock. The assembled thresholds, truncated or zero-extended to the FIFO address width, are continuously available to the flag logic.

Top module: `ofs_prog_port`

## Requirements
- R1: On a rising clock edge with `cfg_sel_n` low and `wr_en_n` low, `wr_data` is stored into the register selected by the pointer, and the pointer advances by one.
- R2: The pointer visits the registers in this order: almost-empty low part (0), almost-empty high part (1), almost-full low part (2), almost-full high part (3). After 3 it returns to 0.
- R3: With `cfg_sel_n` high, `mem_wr` equals the inverse of `wr_en_n` and `mem_rd` equals the inverse of `rd_en_n`. No threshold register, the pointer, or `rd_data` changes.
- R4: With `cfg_sel_n` low, `wr_en_n` high and `rd_en_n` high, nothing changes, and `mem_wr` and `mem_rd` are both low.
- R5: The pointer keeps its position while `cfg_sel_n` is high. The next register access continues at the register that follows the last one accessed.
- R6: On a rising clock edge with `cfg_sel_n` low and `rd_en_n` low, the register selected by the pointer is loaded into `rd_data`, and the pointer advances in the same order as R2.
- R7: While `rst_n` is low, both low-part registers are set to 7, both high-part registers are set to 0, the pointer is set to 0 and `rd_data` is cleared. After reset, `ae_offset` = 7 and `af_offset` = 7.
- R8: `ae_offset` is the concatenation {high part, low part} of the almost-empty registers, and `af_offset` is formed the same way from the almost-full registers. Each is truncated to AW bits. With the defaults (DW=9, AW=16), bits 15:9 come from bits 6:0 of the high part.
- R9: Register writes and register reads share the one pointer. A read that follows two writes returns the third register in the order.
- R10: `rd_data` holds its value on every cycle without a register read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel_n | input | 1 | Low: strobes access the threshold registers; high: strobes go to memory |
| wr_en_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low read strobe |
| wr_data | input | DW | Write word |
| rd_data | output | DW | Last threshold register read back |
| mem_wr | output | 1 | Write request forwarded to FIFO storage |
| mem_rd | output | 1 | Read request forwarded to FIFO storage |
| ae_offset | output | AW | Assembled almost-empty threshold |
| af_offset | output | AW | Assembled almost-full threshold |

## Verification
The assertions assume that a register write and a register read never happen in the same cycle. With `cfg_sel_n` low, `wr_en_n` and `rd_en_n` are never low together, and one check flags any stimulus that breaks this rule. The random stimulus picks one operation per cycle from a fixed menu: register write, register read, memory write, memory read, or an idle cycle with the select either high or low. No menu entry combines the two register strobes. Directed sequences cover partial loads interrupted by the select going high, reads that wrap past the fourth register, and all-ones data that shows the truncation.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

   localparam int NUM_REGS = 4;
   localparam int SEL_W    = $clog2(NUM_REGS);

   typedef enum logic [SEL_W-1:0] {
      SEL_AE_LO = 2'd0,
      SEL_AE_HI = 2'd1,
      SEL_AF_LO = 2'd2,
      SEL_AF_HI = 2'd3
   } reg_sel_t;

   function automatic reg_sel_t next_sel(input reg_sel_t cur);
      return reg_sel_t'(cur + 1'b1);
   endfunction

endpackage

// File: rtl/ofs_sel_ptr.sv
module ofs_sel_ptr
   import ofs_prog_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     acc,
   output reg_sel_t sel
);

   reg_sel_t sel_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= SEL_AE_LO;
      else if (acc)
         sel_q <= next_sel(sel_q);
   end

   assign sel = sel_q;

   // R2
   ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> (sel_q == reg_sel_t'($past(sel_q) + 1'b1)));

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(sel_q));

endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
   import ofs_prog_pkg::*;
#(
   parameter int DW      = 9,
   parameter int LO_INIT = 7,
   parameter int HI_INIT = 0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr,
   input  logic [SEL_W-1:0]             sel,
   input  logic [DW-1:0]                wdata,
   output logic [NUM_REGS-1:0][DW-1:0]  regs
);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
      localparam logic [DW-1:0]    INIT   = (g % 2 == 0) ? DW'(LO_INIT) : DW'(HI_INIT);
      logic [DW-1:0] val_q;

      always_ff @(posedge clk) begin
         if (!rst_n)
            val_q <= INIT;
         else if (wr && (sel == MY_SEL))
            val_q <= wdata;
      end

      assign regs[g] = val_q;
   end

   // R1
   reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (regs[$past(sel)] == $past(wdata)));

   // R4
   reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(regs));

endmodule

// File: rtl/ofs_assemble.sv
module ofs_assemble #(
   parameter int DW = 9,
   parameter int AW = 16
) (
   input  logic [DW-1:0] lo,
   input  logic [DW-1:0] hi,
   output logic [AW-1:0] value
);

   localparam int FULL_W = 2 * DW;

   logic [FULL_W-1:0] joined;
   assign joined = {hi, lo};

   if (AW <= FULL_W) begin : g_trunc
      assign value = joined[AW-1:0];
   end else begin : g_extend
      assign value = {{(AW - FULL_W){1'b0}}, joined};
   end

endmodule

// File: rtl/ofs_prog_port.sv
module ofs_prog_port
   import ofs_prog_pkg::*;
#(
   parameter int DW      = 9,
   parameter int AW      = 16,
   parameter int LO_INIT = 7,
   parameter int HI_INIT = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_sel_n,
   input  logic          wr_en_n,
   input  logic          rd_en_n,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data,
   output logic          mem_wr,
   output logic          mem_rd,
   output logic [AW-1:0] ae_offset,
   output logic [AW-1:0] af_offset
);

   initial begin
      if (DW < 1)  $error("DW must be at least 1");
      if (AW < 1)  $error("AW must be at least 1");
      if (LO_INIT >= (1 << DW) || HI_INIT >= (1 << DW))
         $error("reset thresholds must fit in DW bits");
   end

   logic cfg_wr, cfg_rd, cfg_acc;
   reg_sel_t sel;
   logic [NUM_REGS-1:0][DW-1:0] regs;
   logic [DW-1:0] rd_q;

   assign cfg_wr  = !cfg_sel_n && !wr_en_n;
   assign cfg_rd  = !cfg_sel_n && !rd_en_n && wr_en_n;
   assign cfg_acc = cfg_wr || cfg_rd;
   assign mem_wr  = cfg_sel_n && !wr_en_n;
   assign mem_rd  = cfg_sel_n && !rd_en_n;

   ofs_sel_ptr i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .acc   (cfg_acc),
      .sel   (sel)
   );

   ofs_reg_bank #(
      .DW      (DW),
      .LO_INIT (LO_INIT),
      .HI_INIT (HI_INIT)
   ) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .sel   (sel),
      .wdata (wr_data),
      .regs  (regs)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_q <= '0;
      else if (cfg_rd)
         rd_q <= regs[sel];
   end

   assign rd_data = rd_q;

   ofs_assemble #(.DW(DW), .AW(AW)) i_ae (
      .lo    (regs[SEL_AE_LO]),
      .hi    (regs[SEL_AE_HI]),
      .value (ae_offset)
   );

   ofs_assemble #(.DW(DW), .AW(AW)) i_af (
      .lo    (regs[SEL_AF_LO]),
      .hi    (regs[SEL_AF_HI]),
      .value (af_offset)
   );

   // R9
   no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cfg_sel_n && !wr_en_n && !rd_en_n));

   // R10
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rd |=> $stable(rd_data));

   // R3
   mem_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sel_n |=> ($stable(ae_offset) && $stable(af_offset)));

endmodule

// File: tb/test_ofs_prog_port.sv
module test_ofs_prog_port;

   localparam int DW = 9;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_sel_n = 1'b1;
   logic          wr_en_n = 1'b1;
   logic          rd_en_n = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          mem_wr, mem_rd;
   logic [AW-1:0] ae_offset, af_offset;

   int n_chk = 0;
   int n_err = 0;
   logic [DW-1:0] m_reg [4];
   int            m_ptr;
   logic [DW-1:0] m_rd;

   always #5 clk = ~clk;

   ofs_prog_port #(.DW(DW), .AW(AW)) i_ofs_prog_port (
      .clk(clk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n), .wr_en_n(wr_en_n),
      .rd_en_n(rd_en_n), .wr_data(wr_data), .rd_data(rd_data),
      .mem_wr(mem_wr), .mem_rd(mem_rd), .ae_offset(ae_offset), .af_offset(af_offset)
   );

   function automatic logic [AW-1:0] join_val(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
      logic [2*DW-1:0] j;
      j = {hi, lo};
      return j[AW-1:0];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_reg[0] = 9'd7; m_reg[1] = 9'd0; m_reg[2] = 9'd7; m_reg[3] = 9'd0;
      m_ptr = 0;
      m_rd = '0;
   endtask

   task automatic check_state(input string req);
      check({req, " ae_offset"}, 32'(ae_offset), 32'(join_val(m_reg[0], m_reg[1])));
      check({req, " af_offset"}, 32'(af_offset), 32'(join_val(m_reg[2], m_reg[3])));
      check({req, " rd_data"}, 32'(rd_data), 32'(m_rd));
   endtask

   // one cycle: drive at negedge, check routing, update model at posedge, check after
   task automatic step(input string req, input logic sel_n, input logic w_n,
                       input logic r_n, input logic [DW-1:0] d);
      @(negedge clk);
      cfg_sel_n = sel_n; wr_en_n = w_n; rd_en_n = r_n; wr_data = d;
      #1;
      check({req, " mem_wr"}, 32'(mem_wr), 32'(sel_n && !w_n));
      check({req, " mem_rd"}, 32'(mem_rd), 32'(sel_n && !r_n));
      @(posedge clk);
      if (!sel_n && !w_n) begin
         m_reg[m_ptr] = d;
         m_ptr = (m_ptr + 1) % 4;
      end else if (!sel_n && !r_n) begin
         m_rd = m_reg[m_ptr];
         m_ptr = (m_ptr + 1) % 4;
      end
      #2;
      check_state(req);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      model_reset();
      repeat (3) @(posedge clk);
      #2;
      // R7 reset values
      check("R7 ae reset", 32'(ae_offset), 32'd7);
      check("R7 af reset", 32'(af_offset), 32'd7);
      check("R7 rd reset", 32'(rd_data), 32'd0);
      @(negedge clk); rst_n = 1'b1;

      // R1 R2: load all four in order, R8 truncation with all ones
      step("R1", 1'b0, 1'b0, 1'b1, 9'h1FF);
      step("R2", 1'b0, 1'b0, 1'b1, 9'h1FF);
      check("R8 truncation", 32'(ae_offset), 32'hFFFF);
      step("R2", 1'b0, 1'b0, 1'b1, 9'h055);
      step("R2", 1'b0, 1'b0, 1'b1, 9'h0A3);
      check("R8 af join", 32'(af_offset), 32'h4655);
      // R2 wrap: fifth write lands in almost-empty low part
      step("R2 wrap", 1'b0, 1'b0, 1'b1, 9'h012);
      check("R2 wrap ae", 32'(ae_offset), 32'hFE12);

      // R5 partial load, select high, continue
      step("R3", 1'b1, 1'b0, 1'b1, 9'h1AA);
      step("R3", 1'b1, 1'b1, 1'b0, 9'h1BB);
      step("R4", 1'b0, 1'b1, 1'b1, 9'h1CC);
      step("R5", 1'b0, 1'b0, 1'b1, 9'h034);
      check("R5 continue at hi", 32'(ae_offset), 32'h6812);

      // R6 R9: reads share pointer, now at index 2
      step("R9", 1'b0, 1'b1, 1'b0, 9'h000);
      check("R9 read af lo", 32'(rd_data), 32'h055);
      step("R6", 1'b0, 1'b1, 1'b0, 9'h000);
      step("R6 wrap", 1'b0, 1'b1, 1'b0, 9'h000);
      check("R6 wrap reads ae lo", 32'(rd_data), 32'h012);
      step("R10", 1'b1, 1'b1, 1'b1, 9'h1FF);
      step("R10", 1'b0, 1'b1, 1'b1, 9'h1FF);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int op;
         logic [DW-1:0] d;
         op = int'($urandom_range(0, 5));
         d  = DW'($urandom);
         case (op)
            0: step("R1 rand", 1'b0, 1'b0, 1'b1, d);
            1: step("R6 rand", 1'b0, 1'b1, 1'b0, d);
            2: step("R3 rand", 1'b1, 1'b0, 1'b1, d);
            3: step("R3 rand", 1'b1, 1'b1, 1'b0, d);
            4: step("R4 rand", 1'b0, 1'b1, 1'b1, d);
            default: step("R10 rand", 1'b1, 1'b1, 1'b1, d);
         endcase
      end

      // R7 mid-run reset
      @(negedge clk); rst_n = 1'b0; cfg_sel_n = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
      @(posedge clk); #2;
      model_reset();
      check_state("R7 rerun");
      @(negedge clk); rst_n = 1'b1;
      step("R7 pointer at 0", 1'b0, 1'b1, 1'b0, 9'h000);
      check("R7 first read ae lo", 32'(rd_data), 32'd7);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end

endmodule